// File: doc/BRIEF.md
# Three-level PWM input decoder

This block sits in front of a half-bridge gate sequencer and turns a three-level PWM control input into a clean drive command. The analog front end supplies two comparator flags. One says the input sits above the upper threshold. The other says it sits below the lower threshold. Both flags arrive asynchronously. The block synchronises them, classifies every sample as high, low or mid-window, and keeps a state machine that issues one of three commands: high side on, low side on, or both off.

A mid-window level becomes a command only after it has persisted for a programmable hold-off of `HOLD_CYCLES` samples. At 200 MHz the default of 36 cycles is 180 ns. A shorter visit keeps the previous drive command in effect. Leaving the mid window follows the new level at once, with the same latency as a normal edge.

An open, undriven input rests in the mid window, so a floating pin ends up as both-off. After reset the block reports both-off until it sees the first valid level.

States:
- `ST_OFF`: three-state shutdown, and also the reset state.
- `ST_DRV_HIGH` and `ST_DRV_LOW`: driving the high side or the low side.
- `ST_MID_HIGH` and `ST_MID_LOW`: a mid-window visit in progress, still driving the previous command.

Transitions:
- A high sample leads to `ST_DRV_HIGH` from any state.
- A low sample leads to `ST_DRV_LOW` from any state.
- A mid sample in a drive state leads to the matching mid state, and the hold-off count restarts at 1.
- A mid sample in a mid state advances the count. The state becomes `ST_OFF` once `HOLD_CYCLES` consecutive mid samples have been seen.
- A mid sample in `ST_OFF` stays in `ST_OFF`.

Top module: `trilevel_cmd_decoder`

## Requirements
- R1: During and after reset, until a high or low level has passed the synchronizer, `drive_cmd` is 2'b00 (off) and `tri_off` is 1.
- R2: With `above_hi_async`=1 and `below_lo_async`=0, the sample is high and `drive_cmd` becomes 2'b10. With `above_hi_async`=0 and `below_lo_async`=1, the sample is low and `drive_cmd` becomes 2'b01. Each is due on the third rising clock edge after the flags change.
- R3: A sample with both flags 0, or with both flags 1, is mid-window.
- R4: A run of fewer than `HOLD_CYCLES` consecutive mid samples, after a high or low level, leaves the previous command unchanged for the whole run.
- R5: A run of `HOLD_CYCLES` or more consecutive mid samples sets `drive_cmd` to 2'b00 and `tri_off` to 1, starting from the `HOLD_CYCLES`-th mid sample.
- R6: From the off state, a high or low sample produces 2'b10 or 2'b01 with the same three-edge latency as R2.
- R7: The hold-off count restarts on every new entry into the mid window. Mid runs separated by even one high or low sample do not add up.
- R8: `tri_off` is 1 exactly when `drive_cmd` is 2'b00.
- R9: `drive_cmd` never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| above_hi_async | input | 1 | Comparator flag: input above the upper threshold (asynchronous) |
| below_lo_async | input | 1 | Comparator flag: input below the lower threshold (asynchronous) |
| drive_cmd | output | 2 | 2'b10 high side on, 2'b01 low side on, 2'b00 both off |
| tri_off | output | 1 | 1 while the three-state shutdown is in effect |

## Verification
A flag change applied between clock edges reaches `drive_cmd` on the third rising edge: two synchronizer stages, then the state register. A run of mid samples therefore forces off at edge 2 + `HOLD_CYCLES` after the input entered the window.

The bench drives each input at a falling edge and checks the outputs at every later falling edge. It pushes its stimulus through a three-entry delay line, so the expected command at each check comes from the input applied three cycles earlier. That expected value also depends on the length of the current mid run and on the last high or low level seen. Directed runs of exactly `HOLD_CYCLES`-1 and `HOLD_CYCLES` mid samples, and split runs, pin down the boundary.

// File: rtl/trilevel_pkg.sv
package trilevel_pkg;

    typedef enum logic [1:0] {
        LVL_MID  = 2'b00,
        LVL_LOW  = 2'b01,
        LVL_HIGH = 2'b10
    } level_t;

    typedef enum logic [1:0] {
        CMD_OFF  = 2'b00,
        CMD_LOW  = 2'b01,
        CMD_HIGH = 2'b10
    } cmd_t;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_DRV_HIGH,
        ST_DRV_LOW,
        ST_MID_HIGH,
        ST_MID_LOW
    } dec_state_t;

endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/level_classify.sv
module level_classify
    import trilevel_pkg::*;
(
    input  logic   above_hi,
    input  logic   below_lo,
    output level_t level
);

    always_comb begin
        unique case ({above_hi, below_lo})
            2'b10:   level = LVL_HIGH;
            2'b01:   level = LVL_LOW;
            default: level = LVL_MID;   // 00 or 11: mid window (R3)
        endcase
    end

endmodule

// File: rtl/holdoff_fsm.sv
module holdoff_fsm
    import trilevel_pkg::*;
#(
    parameter int HOLD_CYCLES = 36
) (
    input  logic   clk,
    input  logic   rst_n,
    input  level_t level,
    output cmd_t   cmd,
    output logic   tri_flag
);

    localparam int CW = $clog2(HOLD_CYCLES) + 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(HOLD_CYCLES - 1);

    dec_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // next state and hold-off count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_OFF: begin
                if (level == LVL_HIGH)     state_d = ST_DRV_HIGH;
                else if (level == LVL_LOW) state_d = ST_DRV_LOW;
            end
            ST_DRV_HIGH, ST_DRV_LOW: begin
                if (level == LVL_HIGH)     state_d = ST_DRV_HIGH;
                else if (level == LVL_LOW) state_d = ST_DRV_LOW;
                else begin
                    state_d = (state_q == ST_DRV_HIGH) ? ST_MID_HIGH : ST_MID_LOW;
                    cnt_d   = CW'(1);
                end
            end
            ST_MID_HIGH, ST_MID_LOW: begin
                if (level == LVL_HIGH)     state_d = ST_DRV_HIGH;
                else if (level == LVL_LOW) state_d = ST_DRV_LOW;
                else if (cnt_q == LAST_CNT) begin
                    state_d = ST_OFF;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        tri_flag = 1'b0;
        unique case (state_q)
            ST_DRV_HIGH, ST_MID_HIGH: cmd = CMD_HIGH;
            ST_DRV_LOW,  ST_MID_LOW:  cmd = CMD_LOW;
            default: begin
                cmd      = CMD_OFF;
                tri_flag = 1'b1;
            end
        endcase
    end

    a_r2_follow_high: assert property (@(posedge clk) disable iff (!rst_n)
        level == LVL_HIGH |=> cmd == CMD_HIGH);
    a_r2_follow_low: assert property (@(posedge clk) disable iff (!rst_n)
        level == LVL_LOW |=> cmd == CMD_LOW);
    a_r4_mid_no_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (level == LVL_MID && cmd != CMD_OFF) |=> (cmd == $past(cmd) || cmd == CMD_OFF));
    a_r5_off_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_OFF && level == LVL_MID) |=> cmd == CMD_OFF);
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_CNT);
    a_r8_flag_matches: assert property (@(posedge clk) disable iff (!rst_n)
        tri_flag == (cmd == CMD_OFF));
    a_r9_no_both: assert property (@(posedge clk) disable iff (!rst_n)
        cmd != 2'b11);

endmodule

// File: rtl/trilevel_cmd_decoder.sv
module trilevel_cmd_decoder
    import trilevel_pkg::*;
#(
    parameter int HOLD_CYCLES = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       above_hi_async,
    input  logic       below_lo_async,
    output logic [1:0] drive_cmd,
    output logic       tri_off
);

    logic [1:0] flags_sync;
    level_t     level;
    cmd_t       cmd;

    flag_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({above_hi_async, below_lo_async}),
        .dout  (flags_sync)
    );

    level_classify u_class (
        .above_hi (flags_sync[1]),
        .below_lo (flags_sync[0]),
        .level    (level)
    );

    holdoff_fsm #(.HOLD_CYCLES(HOLD_CYCLES)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (level),
        .cmd      (cmd),
        .tri_flag (tri_off)
    );

    assign drive_cmd = cmd;

endmodule

// File: tb/test_trilevel_cmd_decoder.sv
`timescale 1ns/1ps
module test_trilevel_cmd_decoder;

    localparam int HOLD = 36;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       above_hi_async = 1'b0;
    logic       below_lo_async = 1'b0;
    logic [1:0] drive_cmd;
    logic       tri_off;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // stimulus codes: 0 = mid (00), 1 = low, 2 = high, 3 = mid (11)
    int pipe [3];
    int run_len;
    int last_lvl;   // -1 none, 1 low, 2 high

    always #2.5 clk = ~clk;

    trilevel_cmd_decoder #(.HOLD_CYCLES(HOLD)) i_trilevel_cmd_decoder (
        .clk            (clk),
        .rst_n          (rst_n),
        .above_hi_async (above_hi_async),
        .below_lo_async (below_lo_async),
        .drive_cmd      (drive_cmd),
        .tri_off        (tri_off)
    );

    function automatic logic [1:0] code_of(int lvl);
        if (lvl == 2) return 2'b10;
        if (lvl == 1) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [1:0] expect_cmd(int lvl, int run, int last);
        if (lvl == 1 || lvl == 2) return code_of(lvl);
        if (run >= HOLD || last < 0) return 2'b00;
        return code_of(last);
    endfunction

    task automatic check2(string req, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // at a falling edge: check outputs, then apply the next level
    task automatic step(int lvl, string tag);
        logic [1:0] e;
        string req;
        @(negedge clk);
        if (pipe[2] == 1 || pipe[2] == 2) begin
            run_len  = 0;
            last_lvl = pipe[2];
        end else if (run_len < 100000) begin
            run_len++;
        end
        e = expect_cmd(pipe[2], run_len, last_lvl);
        if (tag != "") req = tag;
        else if (pipe[2] == 1 || pipe[2] == 2) req = "R2";
        else if (pipe[2] == 3) req = "R3";
        else if (e == 2'b00) req = "R5";
        else req = "R4";
        check2(req, drive_cmd, e);
        check2("R8", {1'b0, tri_off}, {1'b0, (e == 2'b00)});
        check2("R9", {1'b0, drive_cmd == 2'b11}, 2'b00);
        above_hi_async = (lvl == 2) || (lvl == 3);
        below_lo_async = (lvl == 1) || (lvl == 3);
        pipe[2] = pipe[1];
        pipe[1] = pipe[0];
        pipe[0] = lvl;
    endtask

    task automatic seg(int lvl, int len, string tag);
        for (int i = 0; i < len; i++) step(lvl, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        pipe[0] = 0; pipe[1] = 0; pipe[2] = 0;
        run_len = 0;
        last_lvl = -1;
        repeat (3) @(negedge clk);
        check2("R1", drive_cmd, 2'b00);
        check2("R1", {1'b0, tri_off}, 2'b01);
        rst_n = 1'b1;
        // R1: floating input after reset stays off
        seg(0, 6, "R1");
        // R6: leave off toward high, then toward low after shutdown
        seg(2, 5, "R6");
        seg(0, HOLD + 4, "");
        seg(1, 5, "R6");
        // R4: mid run of HOLD-1 keeps low
        seg(3, HOLD - 1, "");
        seg(1, 4, "");
        // R5: exactly HOLD mid samples shuts down
        seg(0, HOLD, "");
        seg(2, 4, "");
        // R7: split runs do not accumulate
        seg(0, HOLD - 2, "R7");
        seg(1, 1, "R7");
        seg(0, HOLD - 2, "R7");
        seg(2, 1, "R7");
        seg(3, HOLD - 1, "R7");
        seg(2, 4, "R7");
        // random segments
        for (int k = 0; k < 300; k++) begin
            int lvl = int'($urandom_range(0, 3));
            int len = int'($urandom_range(1, HOLD + 8));
            seg(lvl, len, "");
        end
        seg(0, 4, "");
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule